// File: doc/BRIEF.md
# FIFO Ready-Signal Generator with Block Mode

This block tracks the fill level of one serial channel's receive and transmit queues, each holding up to 64 bytes. From those levels it drives two active-low ready pins that tell an external transfer engine when to unload received data or load more transmit data. It supports three operating modes. With queueing off, each direction is a single holding register. With queueing on and block transfer off, the pins signal data one character at a time. With block transfer on, the engine moves whole bursts sized by a programmable receive threshold.

The block does not store the data bytes. The surrounding logic reports each accepted write into a queue and each read out of it as push and pop strobes, and receives the level counts back. A receive timeout arrives as a one-cycle pulse from an external timer. The receive-ready signal can also be steered onto a shared multi-purpose output pin by a two-bit select field.

All registered outputs change on the same rising edge that applies the push and pop strobes of that cycle.

Top module: `rdy_gen_top`

## Requirements
- R1: While reset is held, both level outputs read 0 and rx_rdy_n, tx_rdy_n and mf_n are all high.
- R2: Each level counts accepted pushes minus accepted pops. Capacity is 64 with fifo_en=1 and 1 with fifo_en=0. A push into a full queue is ignored unless a pop is accepted in the same cycle, and a pop from an empty queue is ignored.
- R3: A push and a pop in the same cycle on a queue whose level is nonzero leave that level unchanged.
- R4: With fifo_en=0, rx_rdy_n is low exactly when the receive holding register holds a byte (level 1), and tx_rdy_n is low exactly when the transmit holding register is empty (level 0).
- R5: With fifo_en=1 and blk_mode=0, rx_rdy_n is low exactly when the receive level is at least 1, and tx_rdy_n is low exactly when the transmit level is 0.
- R6: With fifo_en=1 and blk_mode=1, rx_rdy_n goes low when the receive level reaches the trigger level, or when rx_timeout is high while the level is nonzero. It then stays low until the level returns to 0, and it is always high at level 0.
- R7: rx_trig_sel selects the block-mode receive trigger level: 2'b00 gives 1, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 56 bytes.
- R8: With fifo_en=1 and blk_mode=1, tx_rdy_n is low while the transmit level is below 64 and high when it equals 64.
- R9: On any edge where fifo_en differs from its value at the previous edge, both levels clear to 0 and any push or pop in that cycle is ignored.
- R10: mf_n equals rx_rdy_n when mf_sel is 2'b10, and is high for every other mf_sel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Queueing enable (control bit 0) |
| blk_mode | input | 1 | Block-transfer mode (control bit 3) |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rx_push | input | 1 | Byte written into receive queue |
| rx_pop | input | 1 | Byte read from receive queue |
| tx_push | input | 1 | Byte written into transmit queue |
| tx_pop | input | 1 | Byte taken from transmit queue |
| mf_sel | input | 2 | Multi-purpose pin function select |
| rx_level | output | 7 | Receive queue level, 0 to 64 |
| tx_level | output | 7 | Transmit queue level, 0 to 64 |
| rx_rdy_n | output | 1 | Active-low receive-ready |
| tx_rdy_n | output | 1 | Active-low transmit-ready |
| mf_n | output | 1 | Multi-purpose pin, active low |

## Verification
A corrupted level counter shows on the level outputs at the very next edge, and it also skews every later ready decision. A lost or stuck hysteresis flag in block mode appears at the next edge where the receive level moves between 1 and the trigger. At that edge rx_rdy_n shows the wrong value and keeps it until the queue empties. The bench therefore runs a behavioural model beside the design and compares all five outputs after every edge. It fills and drains at each trigger setting, fires timeouts at low levels, holds the transmit queue full, and toggles the enable mid-level.

// File: rtl/rdy_pkg.sv
package rdy_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_CHAR  = 2'd1,
        MODE_BLOCK = 2'd2
    } rdy_mode_e;

    localparam logic [1:0] MF_SEL_RXRDY = 2'b10;

    // Block-mode receive threshold for a given select code, scaled to depth.
    function automatic int unsigned rx_trig_level(input logic [1:0] sel,
                                                  input int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 8;
            2'b10:   return depth / 4;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/rdy_level_ctr.sv
module rdy_level_ctr #(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fifo_on,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_nxt
);
    localparam logic [LVL_W-1:0] CAP_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] CAP_ONE  = LVL_W'(1);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [LVL_W-1:0] cap;
    logic pop_ok, push_ok;

    always_comb begin
        st_d    = st_q;
        cap     = fifo_on ? CAP_FULL : CAP_ONE;
        pop_ok  = pop && (st_q.lvl != '0);
        push_ok = push && ((st_q.lvl < cap) || pop_ok);
        if (clr) begin
            st_d.lvl = '0;
        end else if (push_ok && !pop_ok) begin
            st_d.lvl = st_q.lvl + CAP_ONE;
        end else if (pop_ok && !push_ok) begin
            st_d.lvl = st_q.lvl - CAP_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q   = st_q.lvl;
    assign lvl_nxt = st_d.lvl;

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |-> (lvl_q <= cap));

    p_pushpop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && (lvl_q != '0) && !clr) |=> (lvl_q == $past(lvl_q)));

endmodule

// File: rtl/rdy_rx_flag.sv
module rdy_rx_flag #(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rdy_pkg::rdy_mode_e mode,
    input  logic [1:0]        trig_sel,
    input  logic              timeout,
    input  logic [LVL_W-1:0]  lvl_nxt,
    output logic              rdy_n_q
);
    typedef struct packed {
        logic rdy_n;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [LVL_W-1:0] trig;

    always_comb begin
        st_d = st_q;
        trig = LVL_W'(rdy_pkg::rx_trig_level(trig_sel, DEPTH));
        case (mode)
            rdy_pkg::MODE_BLOCK: begin
                if (lvl_nxt == '0)                         st_d.rdy_n = 1'b1;
                else if ((lvl_nxt >= trig) || timeout)     st_d.rdy_n = 1'b0;
            end
            default: st_d.rdy_n = (lvl_nxt == '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rdy_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rdy_n_q = st_q.rdy_n;

    // Between empty and trigger, block mode holds its previous decision.
    p_hyst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == rdy_pkg::MODE_BLOCK) && (lvl_nxt != '0) && (lvl_nxt < trig) && !timeout)
        |=> $stable(rdy_n_q));

endmodule

// File: rtl/rdy_tx_flag.sv
module rdy_tx_flag #(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  rdy_pkg::rdy_mode_e mode,
    input  logic [LVL_W-1:0]   lvl_nxt,
    output logic               rdy_n_q
);
    localparam logic [LVL_W-1:0] CAP_FULL = LVL_W'(DEPTH);

    typedef struct packed {
        logic rdy_n;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode == rdy_pkg::MODE_BLOCK) st_d.rdy_n = (lvl_nxt == CAP_FULL);
        else                             st_d.rdy_n = (lvl_nxt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rdy_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rdy_n_q = st_q.rdy_n;

endmodule

// File: rtl/rdy_gen_top.sv
module rdy_gen_top #(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             blk_mode,
    input  logic [1:0]       rx_trig_sel,
    input  logic             rx_timeout,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic [1:0]       mf_sel,
    output logic [LVL_W-1:0] rx_level,
    output logic [LVL_W-1:0] tx_level,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n,
    output logic             mf_n
);
    localparam int N_DIR = 2;   // index 0 = receive, 1 = transmit

    typedef struct packed {
        logic en;
    } top_st_t;

    top_st_t st_d, st_q;
    rdy_pkg::rdy_mode_e mode;
    logic clr;
    logic [N_DIR-1:0] push_v, pop_v;
    logic [LVL_W-1:0] lvl_q_v [N_DIR];
    logic [LVL_W-1:0] lvl_n_v [N_DIR];

    always_comb begin
        st_d    = st_q;
        st_d.en = fifo_en;
        clr     = (fifo_en != st_q.en);
        if (!fifo_en)      mode = rdy_pkg::MODE_HOLD;
        else if (blk_mode) mode = rdy_pkg::MODE_BLOCK;
        else               mode = rdy_pkg::MODE_CHAR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_v = {tx_push, rx_push};
    assign pop_v  = {tx_pop,  rx_pop};

    for (genvar g = 0; g < N_DIR; g++) begin : g_ctr
        rdy_level_ctr #(.DEPTH(DEPTH)) ctr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .fifo_on (fifo_en),
            .push    (push_v[g]),
            .pop     (pop_v[g]),
            .lvl_q   (lvl_q_v[g]),
            .lvl_nxt (lvl_n_v[g])
        );
    end

    rdy_rx_flag #(.DEPTH(DEPTH)) rx_flag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .trig_sel (rx_trig_sel),
        .timeout  (rx_timeout),
        .lvl_nxt  (lvl_n_v[0]),
        .rdy_n_q  (rx_rdy_n)
    );

    rdy_tx_flag #(.DEPTH(DEPTH)) tx_flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .lvl_nxt (lvl_n_v[1]),
        .rdy_n_q (tx_rdy_n)
    );

    assign rx_level = lvl_q_v[0];
    assign tx_level = lvl_q_v[1];
    assign mf_n     = (mf_sel == rdy_pkg::MF_SEL_RXRDY) ? rx_rdy_n : 1'b1;

    p_empty_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> rx_rdy_n);

    p_hold_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !st_q.en) |=> ((rx_rdy_n == (rx_level == '0)) && (tx_rdy_n == (tx_level != '0))));

    p_blk_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && st_q.en && blk_mode) |=> (tx_rdy_n == (tx_level == LVL_W'(DEPTH))));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != st_q.en) |=> ((rx_level == '0) && (tx_level == '0)));

endmodule

// File: tb/rdy_gen_top_tb_top.sv
`timescale 1ns/1ps
module rdy_gen_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, blk_mode = 1'b0, rx_timeout = 1'b0;
    logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [1:0] rx_trig_sel = 2'b00, mf_sel = 2'b00;
    logic [6:0] rx_level, tx_level;
    logic rx_rdy_n, tx_rdy_n, mf_n;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit started = 0;

    // behavioural reference state
    int rx_l = 0, tx_l = 0;
    bit en_m = 0, rx_m = 1, tx_m = 1;
    string lv_tag = "R1", rx_tag = "R1", tx_tag = "R1";

    always #2.5 clk = ~clk;

    rdy_gen_top dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
        .rx_trig_sel(rx_trig_sel), .rx_timeout(rx_timeout),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .mf_sel(mf_sel), .rx_level(rx_level), .tx_level(tx_level),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .mf_n(mf_n)
    );

    function automatic int next_lvl(int l, bit pu, bit po, int cap, bit clr);
        bit po_ok, pu_ok;
        if (clr) return 0;
        po_ok = po && (l > 0);
        pu_ok = pu && ((l < cap) || po_ok);
        return l + int'(pu_ok) - int'(po_ok);
    endfunction

    always @(posedge clk) begin
        bit clr;
        int cap, trig;
        started = 1;
        cyc++;
        if (!rst_n) begin
            rx_l = 0; tx_l = 0; en_m = 0; rx_m = 1; tx_m = 1;
            lv_tag = "R1"; rx_tag = "R1"; tx_tag = "R1";
        end else begin
            clr  = (fifo_en != en_m);
            en_m = fifo_en;
            cap  = fifo_en ? 64 : 1;
            rx_l = next_lvl(rx_l, rx_push, rx_pop, cap, clr);
            tx_l = next_lvl(tx_l, tx_push, tx_pop, cap, clr);
            case (rx_trig_sel)
                2'b00: trig = 1;
                2'b01: trig = 8;
                2'b10: trig = 16;
                default: trig = 56;
            endcase
            if (!fifo_en || !blk_mode) rx_m = (rx_l == 0);
            else if (rx_l == 0) rx_m = 1;
            else if (rx_l >= trig || rx_timeout) rx_m = 0;
            tx_m = (fifo_en && blk_mode) ? (tx_l == 64) : (tx_l != 0);
            lv_tag = clr ? "R9" : "R2/R3";
            rx_tag = !fifo_en ? "R4" : (blk_mode ? "R6/R7" : "R5");
            tx_tag = !fifo_en ? "R4" : (blk_mode ? "R8" : "R5");
        end
    end

    task automatic chk(string tag, string nm, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, nm, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(lv_tag, "rx_level", int'(rx_level), rx_l);
            chk(lv_tag, "tx_level", int'(tx_level), tx_l);
            chk(rx_tag, "rx_rdy_n", int'(rx_rdy_n), int'(rx_m));
            chk(tx_tag, "tx_rdy_n", int'(tx_rdy_n), int'(tx_m));
            chk("R10", "mf_n", int'(mf_n), (mf_sel == 2'b10) ? int'(rx_m) : 1);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic step(int n, int prx, int qrx, int ptx, int qtx, int pto);
        repeat (n) begin
            @(negedge clk); #1;
            rx_push    = ($urandom % 100) < prx;
            rx_pop     = ($urandom % 100) < qrx;
            tx_push    = ($urandom % 100) < ptx;
            tx_pop     = ($urandom % 100) < qtx;
            rx_timeout = ($urandom % 100) < pto;
            mf_sel     = 2'($urandom % 4);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);                // R1 checked during reset
        #1 rst_n = 1'b1;
        // R4: single holding registers
        step(200, 50, 40, 50, 40, 0);
        // R5: character mode, fill then drain
        @(negedge clk); #1 fifo_en = 1'b1;
        step(150, 80, 10, 80, 10, 0);
        step(150, 10, 80, 10, 80, 0);
        step(100, 50, 50, 50, 50, 0);
        // R6 R7 R8: block mode at every trigger setting
        @(negedge clk); #1 blk_mode = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); #1 rx_trig_sel = 2'(s);
            step(130, 60, 0, 70, 0, 0);
            step(40, 30, 30, 30, 30, 0);
            step(160, 0, 70, 5, 60, 0);
            step(40, 20, 15, 20, 20, 15);
            step(60, 0, 80, 0, 80, 0);
        end
        // R9: toggle enable with queues occupied
        step(60, 70, 5, 70, 5, 0);
        @(negedge clk); #1 fifo_en = 1'b0;
        step(30, 50, 30, 50, 30, 0);
        @(negedge clk); #1 fifo_en = 1'b1;
        step(60, 60, 20, 60, 20, 5);
        @(negedge clk); #1 blk_mode = 1'b0;
        step(60, 40, 40, 40, 40, 5);
        @(negedge clk); #1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule